// File: doc/BRIEF.md
# Ordered Store Buffer with Atomic Support

This block sits between a processor core and its first-level data cache on a machine that keeps stores in program order. The core hands it stores and atomic read-modify-write requests, one per cycle. Each request carries a cache-line address, a byte offset inside the 64-byte line, a size of 1 to 8 bytes, up to 8 bytes of data, a thread number and a program counter. The buffer stores them in a circular queue. A plain store is acknowledged to the core in the cycle it is taken. An atomic is not acknowledged until the cache has granted its line.

Entries leave the buffer strictly in arrival order, with only one request outstanding to the cache. When the cache returns a grant with the current line contents, the buffer overwrites the selected bytes with the entry's data and hands the merged line back. For an atomic, the old bytes of its range are first returned to the core together with the acknowledgement. While an atomic is held, no further request is taken, so an atomic is always the last entry in the queue.

The buffer also sends a prefetch hint for a newly taken address when older entries are already waiting. An age watchdog raises a sticky flag if the outstanding entry has waited too long.

Top module: `tso_store_buffer`

## Requirements
- R1: `in_ready` is high exactly when the occupancy is below DEPTH (128) and no atomic is held. The queue is a ring whose indices wrap from DEPTH-1 to 0. A request is taken on `in_valid && in_ready`, and a take and a removal in the same cycle leave the occupancy unchanged.
- R2: `st_ack` is high in the same cycle as a taken request whose `in_atomic` is 0. An atomic (`in_atomic`=1) produces no `st_ack`.
- R3: After an atomic is taken, `in_ready` is low from the next cycle onward. It is high again in the cycle in which `amo_ack` is high.
- R4: When the queue holds entries and nothing is outstanding, `drn_valid` pulses for one cycle, one cycle after the entry becomes available. It carries the oldest entry's line, offset, size, type, PC and thread. No second pulse occurs before the grant, and entries are issued in arrival order.
- R5: A grant (`gnt_valid`) is accepted only while a request is outstanding and `gnt_line` equals `drn_line`. Any other grant is ignored: it causes no `wb_valid`, and the request stays outstanding.
- R6: One cycle after an accepted grant, `wb_valid` pulses and `wb_line` equals `drn_line`. In `wb_data`, line byte b (bits 8b+7:8b) is replaced by data byte b-offset for every offset ≤ b < offset+size. All other bytes equal `gnt_data`, and bytes that would fall beyond byte 63 are dropped.
- R7: For an atomic, `amo_ack` pulses together with `wb_valid`. Byte i of `amo_load` equals line byte offset+i of `gnt_data` (as it was before the merge) for i < size and offset+i ≤ 63, and is zero otherwise. The queue is empty afterwards.
- R8: If more entries wait when a grant is accepted, the next `drn_valid` pulse occurs in the same cycle as the `wb_valid` for that grant.
- R9: One cycle after a request is taken while the queue already held at least one entry, `pf_valid` pulses with `pf_line` equal to the new line. A request taken into an empty queue gives no prefetch.
- R10: With a request outstanding whose insert was k cycles ago, `deadlock` becomes high after the clock edge at which k reaches `dl_limit`. Once high, it stays high until reset.
- R11: After reset, `in_ready`=1 and `drn_valid`, `wb_valid`, `amo_ack`, `pf_valid` and `deadlock` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Core offers a request |
| in_atomic | input | 1 | 1 = atomic, 0 = plain store |
| in_line | input | LINE_W | Line address of the request |
| in_off | input | 6 | Byte offset inside the line |
| in_size | input | 4 | Size in bytes, 1 to 8 |
| in_data | input | 64 | Store data, byte 0 in bits 7:0 |
| in_thread | input | TID_W | Thread number |
| in_pc | input | PC_W | Program counter of the request |
| in_ready | output | 1 | Request can be taken this cycle |
| st_ack | output | 1 | Plain store acknowledged this cycle |
| dl_limit | input | TS_W | Age threshold for the watchdog, in cycles |
| drn_valid | output | 1 | Drain request pulse to the cache |
| drn_atomic | output | 1 | Type of the outstanding request |
| drn_line | output | LINE_W | Line address of the outstanding request |
| drn_off | output | 6 | Byte offset of the outstanding request |
| drn_size | output | 4 | Size of the outstanding request |
| drn_thread | output | TID_W | Thread of the outstanding request |
| drn_pc | output | PC_W | PC of the outstanding request |
| gnt_valid | input | 1 | Cache grants a line |
| gnt_line | input | LINE_W | Line address of the grant |
| gnt_data | input | 512 | Current contents of the granted line |
| wb_valid | output | 1 | Merged line is valid |
| wb_line | output | LINE_W | Line address of the merged line |
| wb_data | output | 512 | Granted line with the entry's bytes merged in |
| amo_ack | output | 1 | Atomic acknowledgement |
| amo_load | output | 64 | Old bytes of the atomic's range |
| pf_valid | output | 1 | Prefetch hint pulse |
| pf_line | output | LINE_W | Line address of the prefetch hint |
| deadlock | output | 1 | Sticky watchdog flag |

## Verification
The full queue is the hardest state to reach, together with the ring indices wrapping. It takes 128 back-to-back takes with no grant. The bench first leaves the ring indices away from zero with a short ordered run. It then fills all 128 slots while holding the oldest grant back, offers a further store against the low `in_ready`, and releases a single grant in that cycle. Draining the remaining 127 entries in order then carries both indices across the wrap. The watchdog is reached by lowering `dl_limit` and withholding the grant for an exact number of cycles.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int LINE_BYTES = 64;
  localparam int LINE_BITS  = LINE_BYTES * 8;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int SIZE_W     = 4;
  localparam int DATA_BYTES = 8;
  localparam int DATA_W     = DATA_BYTES * 8;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int DEPTH = 128,
  parameter int W     = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  input  logic             look_next,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [IDX_W-1:0] head, tail, rd_idx;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push) mem[tail] <= wdata;
  end

  assign rd_idx = look_next ? step(head) : head;
  assign rdata  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= step(tail);
      if (pop)  head <= step(head);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push && !pop |-> count < CNT_W'(DEPTH)); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    push && pop |=> $stable(count)); // R1
endmodule

// File: rtl/sb_merge.sv
module sb_merge
  import sb_pkg::*;
(
  input  logic [LINE_BITS-1:0] line_in,
  input  logic [OFF_W-1:0]     off,
  input  logic [SIZE_W-1:0]    size,
  input  logic [DATA_W-1:0]    data,
  output logic [LINE_BITS-1:0] line_out,
  output logic [DATA_W-1:0]    load_out
);
  // merge: each line byte picks store data when inside [off, off+size)
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    logic [OFF_W:0] rel;
    logic           hit;
    assign rel = (OFF_W+1)'(b) - {1'b0, off};
    assign hit = ((OFF_W+1)'(b) >= {1'b0, off}) &&
                 (rel < (OFF_W+1)'(size));
    assign line_out[b*8 +: 8] = hit ? data[rel[2:0]*8 +: 8]
                                    : line_in[b*8 +: 8];
  end

  // old bytes of the range, right-aligned, zero above size or past the line
  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_load
    logic [OFF_W:0] src;
    logic           ok;
    assign src = {1'b0, off} + (OFF_W+1)'(i);
    assign ok  = (SIZE_W'(i) < size) && !src[OFF_W];
    assign load_out[i*8 +: 8] = ok ? line_in[src[OFF_W-1:0]*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/sb_watchdog.sv
module sb_watchdog #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic [TS_W-1:0] stamp,
  input  logic [TS_W-1:0] limit,
  output logic [TS_W-1:0] now,
  output logic            deadlock
);
  logic [TS_W-1:0] age;
  assign age = now - stamp;

  always_ff @(posedge clk) begin
    if (rst) begin
      now      <= '0;
      deadlock <= 1'b0;
    end else begin
      now      <= now + 1'b1;
      deadlock <= deadlock | (active && (age >= limit));
    end
  end

  AST_DL_STICKY: assert property (@(posedge clk) disable iff (rst)
    deadlock |=> deadlock); // R10
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int LINE_W = 26,
  parameter int PC_W   = 32,
  parameter int TID_W  = 4,
  parameter int TS_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_atomic,
  input  logic [LINE_W-1:0]    in_line,
  input  logic [OFF_W-1:0]     in_off,
  input  logic [SIZE_W-1:0]    in_size,
  input  logic [DATA_W-1:0]    in_data,
  input  logic [TID_W-1:0]     in_thread,
  input  logic [PC_W-1:0]      in_pc,
  output logic                 in_ready,
  output logic                 st_ack,
  input  logic [TS_W-1:0]      dl_limit,
  output logic                 drn_valid,
  output logic                 drn_atomic,
  output logic [LINE_W-1:0]    drn_line,
  output logic [OFF_W-1:0]     drn_off,
  output logic [SIZE_W-1:0]    drn_size,
  output logic [TID_W-1:0]     drn_thread,
  output logic [PC_W-1:0]      drn_pc,
  input  logic                 gnt_valid,
  input  logic [LINE_W-1:0]    gnt_line,
  input  logic [LINE_BITS-1:0] gnt_data,
  output logic                 wb_valid,
  output logic [LINE_W-1:0]    wb_line,
  output logic [LINE_BITS-1:0] wb_data,
  output logic                 amo_ack,
  output logic [DATA_W-1:0]    amo_load,
  output logic                 pf_valid,
  output logic [LINE_W-1:0]    pf_line,
  output logic                 deadlock
);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int ENTRY_W = 1 + LINE_W + OFF_W + SIZE_W + DATA_W + TID_W + PC_W + TS_W;

  logic [CNT_W-1:0]   count;
  logic [ENTRY_W-1:0] wr_entry, rd_entry;
  logic [TS_W-1:0]    now;
  logic               push, gnt_ok, avail, issue;
  logic               pending, amo_seen;

  // fields of the entry read from the queue
  logic               e_amo;
  logic [LINE_W-1:0]  e_line;
  logic [OFF_W-1:0]   e_off;
  logic [SIZE_W-1:0]  e_size;
  logic [DATA_W-1:0]  e_data;
  logic [TID_W-1:0]   e_thread;
  logic [PC_W-1:0]    e_pc;
  logic [TS_W-1:0]    e_ts;

  // copy of the outstanding entry's data and timestamp
  logic [DATA_W-1:0]  drn_data;
  logic [TS_W-1:0]    drn_ts;

  logic [LINE_BITS-1:0] merged;
  logic [DATA_W-1:0]    loaded;

  assign in_ready = (count < CNT_W'(DEPTH)) && !amo_seen;
  assign push     = in_valid && in_ready;
  assign st_ack   = push && !in_atomic;
  assign gnt_ok   = gnt_valid && pending && (gnt_line == drn_line);
  assign avail    = gnt_ok ? (count > CNT_W'(1)) : (count != '0);
  assign issue    = (!pending || gnt_ok) && avail;

  assign wr_entry = {in_atomic, in_line, in_off, in_size, in_data, in_thread, in_pc, now};
  assign {e_amo, e_line, e_off, e_size, e_data, e_thread, e_pc, e_ts} = rd_entry;

  sb_queue #(.DEPTH(DEPTH), .W(ENTRY_W)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .wdata     (wr_entry),
    .pop       (gnt_ok),
    .look_next (gnt_ok),
    .rdata     (rd_entry),
    .count     (count)
  );

  sb_merge u_merge (
    .line_in  (gnt_data),
    .off      (drn_off),
    .size     (drn_size),
    .data     (drn_data),
    .line_out (merged),
    .load_out (loaded)
  );

  sb_watchdog #(.TS_W(TS_W)) u_wd (
    .clk      (clk),
    .rst      (rst),
    .active   (pending),
    .stamp    (drn_ts),
    .limit    (dl_limit),
    .now      (now),
    .deadlock (deadlock)
  );

  // control flags
  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      amo_seen  <= 1'b0;
      drn_valid <= 1'b0;
      wb_valid  <= 1'b0;
      amo_ack   <= 1'b0;
      pf_valid  <= 1'b0;
    end else begin
      drn_valid <= issue;
      if (issue)       pending <= 1'b1;
      else if (gnt_ok) pending <= 1'b0;
      if (push && in_atomic)         amo_seen <= 1'b1;
      else if (gnt_ok && drn_atomic) amo_seen <= 1'b0;
      wb_valid  <= gnt_ok;
      amo_ack   <= gnt_ok && drn_atomic;
      pf_valid  <= push && (count != '0);
    end
  end

  // datapath registers, no reset needed
  always_ff @(posedge clk) begin
    if (issue) begin
      drn_atomic <= e_amo;
      drn_line   <= e_line;
      drn_off    <= e_off;
      drn_size   <= e_size;
      drn_data   <= e_data;
      drn_thread <= e_thread;
      drn_pc     <= e_pc;
      drn_ts     <= e_ts;
    end
    if (gnt_ok) begin
      wb_line  <= drn_line;
      wb_data  <= merged;
      amo_load <= loaded;
    end
    if (push) pf_line <= in_line;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    pending && !gnt_ok |=> !drn_valid); // R4
  AST_AMO_LAST: assert property (@(posedge clk) disable iff (rst)
    gnt_ok && drn_atomic |=> count == '0); // R7
  AST_ACK_WITH_WB: assert property (@(posedge clk) disable iff (rst)
    amo_ack |-> wb_valid); // R7
  AST_AMO_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    push && in_atomic |=> !in_ready); // R3
endmodule

// File: tb/tso_store_buffer_test.sv
module tso_store_buffer_test;
  localparam int LINE_W = 26;
  localparam int PC_W   = 32;
  localparam int TID_W  = 4;
  localparam int TS_W   = 32;
  localparam int DEPTH  = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              in_valid = 0, in_atomic = 0;
  logic [LINE_W-1:0] in_line = '0;
  logic [5:0]        in_off = '0;
  logic [3:0]        in_size = '0;
  logic [63:0]       in_data = '0;
  logic [TID_W-1:0]  in_thread = '0;
  logic [PC_W-1:0]   in_pc = '0;
  logic              in_ready, st_ack;
  logic [TS_W-1:0]   dl_limit = 32'd100000;
  logic              drn_valid, drn_atomic;
  logic [LINE_W-1:0] drn_line;
  logic [5:0]        drn_off;
  logic [3:0]        drn_size;
  logic [TID_W-1:0]  drn_thread;
  logic [PC_W-1:0]   drn_pc;
  logic              gnt_valid = 0;
  logic [LINE_W-1:0] gnt_line = '0;
  logic [511:0]      gnt_data = '0;
  logic              wb_valid;
  logic [LINE_W-1:0] wb_line;
  logic [511:0]      wb_data;
  logic              amo_ack;
  logic [63:0]       amo_load;
  logic              pf_valid;
  logic [LINE_W-1:0] pf_line;
  logic              deadlock;

  tso_store_buffer #(.DEPTH(DEPTH), .LINE_W(LINE_W), .PC_W(PC_W),
                     .TID_W(TID_W), .TS_W(TS_W)) uut (.*);

  int  nchk = 0, nfail = 0;
  bit  done = 0;

  typedef struct packed {
    logic        amo;
    logic [5:0]  off;
    logic [3:0]  sz;
    logic [63:0] dat;
    logic [7:0]  seed;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 6'd0,  4'd8, 64'h1122334455667788, 8'h10},
    '{1'b0, 6'd5,  4'd1, 64'h00000000000000AB, 8'h20},
    '{1'b0, 6'd60, 4'd4, 64'h00000000DEADBEEF, 8'h30},
    '{1'b1, 6'd8,  4'd8, 64'hCAFEF00D12345678, 8'h40},
    '{1'b0, 6'd63, 4'd2, 64'h0000000000007E5A, 8'h50},
    '{1'b1, 6'd30, 4'd3, 64'h0000000000A1B2C3, 8'h60}
  };

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [511:0] pat(input logic [7:0] seed);
    logic [511:0] r;
    for (int b = 0; b < 64; b++) r[b*8 +: 8] = seed + 8'(b * 3);
    return r;
  endfunction

  function automatic logic [511:0] exp_merge(input logic [511:0] ln, input int off,
                                             input int sz, input logic [63:0] d);
    logic [511:0] r = ln;
    for (int b = 0; b < 64; b++)
      if (b >= off && b < off + sz) r[b*8 +: 8] = d[(b-off)*8 +: 8];
    return r;
  endfunction

  function automatic logic [63:0] exp_load(input logic [511:0] ln, input int off, input int sz);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++)
      if (i < sz && off + i < 64) r[i*8 +: 8] = ln[(off+i)*8 +: 8];
    return r;
  endfunction

  task automatic offer(input logic amo, input logic [LINE_W-1:0] ln, input logic [5:0] off,
                       input logic [3:0] sz, input logic [63:0] d);
    in_valid = 1; in_atomic = amo; in_line = ln; in_off = off; in_size = sz; in_data = d;
    in_thread = 4'(ln); in_pc = 32'h4000 + 32'(ln);
  endtask

  task automatic grant(input logic [LINE_W-1:0] ln, input logic [511:0] d);
    gnt_valid = 1; gnt_line = ln; gnt_data = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    // R11 reset state
    chk("R11 in_ready", 512'(in_ready), 512'(1));
    chk("R11 outputs quiet", 512'({drn_valid, wb_valid, amo_ack, pf_valid, deadlock}), 512'(0));

    // vector table: single entry each, merge and atomic load
    for (int k = 0; k < 6; k++) begin
      vec_t v = VEC[k];
      logic [LINE_W-1:0] ln = LINE_W'(100 + k);
      offer(v.amo, ln, v.off, v.sz, v.dat);
      #1;
      chk("R2 st_ack at take", 512'(st_ack), 512'(!v.amo));
      cyc();
      in_valid = 0;
      chk("R9 no prefetch into empty queue", 512'(pf_valid), 512'(0));
      cyc();
      chk("R4 drain pulse", 512'({drn_valid, drn_atomic, drn_line, drn_off, drn_size}),
          512'({1'b1, v.amo, ln, v.off, v.sz}));
      chk("R4 drain pc/thread", 512'({drn_pc, drn_thread}), 512'({32'h4000 + 32'(ln), 4'(ln)}));
      if (v.amo) begin
        offer(1'b0, 26'd999, 6'd0, 4'd1, 64'h1);
        #1;
        chk("R3 blocked after atomic", 512'({in_ready, st_ack}), 512'(0));
      end
      grant(ln, pat(v.seed));
      cyc();
      gnt_valid = 0; in_valid = 0;
      chk("R6 wb line", 512'({wb_valid, wb_line}), 512'({1'b1, ln}));
      chk("R6 merged data", wb_data, exp_merge(pat(v.seed), v.off, v.sz, v.dat));
      chk("R7 amo_ack", 512'(amo_ack), 512'(v.amo));
      if (v.amo) begin
        chk("R7 loaded bytes", 512'(amo_load), 512'(exp_load(pat(v.seed), v.off, v.sz)));
        chk("R3 ready with ack", 512'(in_ready), 512'(1));
      end
      cyc();
    end

    // R5 mismatched grant ignored
    offer(1'b0, 26'd200, 6'd4, 4'd2, 64'h55AA);
    cyc(); in_valid = 0;
    cyc();
    grant(26'd201, pat(8'h70));
    cyc();
    chk("R5 wrong line ignored", 512'(wb_valid), 512'(0));
    grant(26'd200, pat(8'h70));
    cyc(); gnt_valid = 0;
    chk("R5 matching grant taken", 512'({wb_valid, wb_line}), 512'({1'b1, 26'd200}));
    cyc();

    // R8/R9/R4 ordered run of three
    offer(1'b0, 26'd10, 6'd0, 4'd1, 64'h1);
    cyc();
    offer(1'b0, 26'd11, 6'd0, 4'd1, 64'h2);
    cyc();
    chk("R9 prefetch second", 512'({pf_valid, pf_line}), 512'({1'b1, 26'd11}));
    chk("R4 first drain", 512'({drn_valid, drn_line}), 512'({1'b1, 26'd10}));
    offer(1'b0, 26'd12, 6'd0, 4'd1, 64'h3);
    cyc(); in_valid = 0;
    chk("R9 prefetch third", 512'({pf_valid, pf_line}), 512'({1'b1, 26'd12}));
    chk("R4 single outstanding", 512'(drn_valid), 512'(0));
    for (int i = 0; i < 3; i++) begin
      grant(LINE_W'(10 + i), pat(8'h00));
      cyc();
      chk("R8 wb in order", 512'({wb_valid, wb_line}), 512'({1'b1, LINE_W'(10 + i)}));
      chk("R8 next drain same cycle", 512'({drn_valid, drn_line}),
          512'({i < 2, (i < 2) ? LINE_W'(11 + i) : drn_line}));
    end
    gnt_valid = 0;
    cyc();

    // R1 fill to capacity, wrap across the ring
    for (int i = 0; i < DEPTH; i++) begin
      offer(1'b0, LINE_W'(1000 + i), 6'd0, 4'd1, 64'(i));
      cyc();
    end
    offer(1'b0, 26'd999, 6'd0, 4'd1, 64'h9);
    #1;
    chk("R1 full not ready", 512'({in_ready, st_ack}), 512'(0));
    grant(26'd1000, pat(8'h01));
    cyc(); in_valid = 0;
    chk("R1 ready after one leaves", 512'({in_ready, wb_valid}), 512'(2'b11));
    for (int i = 1; i < DEPTH; i++) begin
      grant(LINE_W'(1000 + i), pat(8'h01));
      cyc();
      if (wb_line !== LINE_W'(1000 + i) || !wb_valid)
        chk("R1 drain order after wrap", 512'(wb_line), 512'(LINE_W'(1000 + i)));
    end
    gnt_valid = 0;
    cyc();
    chk("R1 empty after drain", 512'({in_ready, drn_valid}), 512'(2'b10));

    // R10 watchdog
    dl_limit = 32'd20;
    offer(1'b0, 26'd300, 6'd0, 4'd1, 64'h1);
    cyc(); in_valid = 0;
    repeat (18) cyc();
    chk("R10 below limit", 512'(deadlock), 512'(0));
    repeat (3) cyc();
    chk("R10 past limit", 512'(deadlock), 512'(1));
    grant(26'd300, pat(8'h02));
    cyc(); gnt_valid = 0;
    repeat (2) cyc();
    chk("R10 sticky", 512'(deadlock), 512'(1));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule